// File: doc/BRIEF.md
# Two-Phase Transmit Credit Tracker

This block sits in the sending IP's clock domain, at the transmit side of an end-to-end channel. The channel uses two-phase signalling and ends in a small receive buffer on the far side. The local IP offers flits through a valid/ready handshake. For each flit that is taken, the block registers the data onto the link and inverts the request line. One inversion announces exactly one flit. The far receiver reads flits out of its buffer in order, and it inverts the acknowledge line once for each flit it reads.

The block never waits for a flit's acknowledge before it sends the next one. It instead keeps a local copy of the receiver's two Johnson-counter pointers:
- The write pointer steps on every local request inversion.
- The read pointer steps on every acknowledge inversion, once that inversion has passed a two-flop synchronizer.

Comparing the two pointers bit by bit gives one free flag per remote slot. A flit is accepted only when the slot it would land in is free. With seven slots, the round trip through both synchronizers is covered, so equal clocks on both sides keep a steady rate of one flit per cycle.

Top module: `tx_credit_tracker`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, `link_req` is 0, `slot_free` is all ones and `in_ready` is 1.
- R2: A cycle with `in_valid` and `in_ready` both high inverts `link_req` at the next rising edge. In that same edge `link_data` takes the offered `in_data`, so both change together.
- R3: `in_ready` equals the free flag of the slot the next flit would use. While it is low, `in_valid` causes no inversion of `link_req`, so an occupied slot is never written.
- R4: Slots are written in the fixed order 0, 1, … DEPTH-1, then 0 again. Bit i of `slot_free` goes to 0 at the edge that writes slot i.
- R5: An inversion of `link_ack` frees the oldest occupied slot. Its flag returns to 1 at the third rising edge after the inversion and not before: two edges of synchronizer, one of edge detection.
- R6: `link_data` and `link_req` hold their values in every cycle without an accepted flit.
- R7: With DEPTH = 7, suppose every flit is acknowledged three cycles after it is sent. A source that offers a flit every cycle then sees `in_ready` stay high and sends one flit per cycle.
- R8: The pointers wrap without loss. Once every sent flit has been acknowledged, all slots read free again, and `link_req` equals the parity of the total number of flits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sending IP clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | IP offers a flit |
| in_ready | output | 1 | Next remote slot is free; the flit is taken this cycle |
| in_data | input | DATA_W | Flit from the IP |
| link_data | output | DATA_W | Flit presented to the remote buffer |
| link_req | output | 1 | Two-phase request; each inversion announces one flit |
| link_ack | input | 1 | Two-phase acknowledge from the receiver, asynchronous |
| slot_free | output | DEPTH | Per-slot free flags of the remote buffer |

## Verification
The bench builds the block with DATA_W = 16 and DEPTH = 7. With seven slots, a run of seven unacknowledged flits fills the buffer, so the full condition and the stall are quick to reach. The same seven slots are exactly enough for the three-cycle acknowledge loop of R7, which checks that the round trip is covered with no bubble. Random bursts make the 14-state Johnson pointers wrap many times. The directed synchronizer test measures the exact edge at which a freed slot comes back.

// File: rtl/tx_credit_pkg.sv
package tx_credit_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_SLOTS  = 7;
    localparam int unsigned DEF_SYNC   = 2;

    typedef enum logic {
        PHASE_LO = 1'b0,
        PHASE_HI = 1'b1
    } phase_e;

    function automatic phase_e phase_flip(input phase_e p);
        return (p == PHASE_LO) ? PHASE_HI : PHASE_LO;
    endfunction

endpackage

// File: rtl/tx_ack_sync.sv
module tx_ack_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic toggled
);
    localparam int unsigned NFF = STAGES + 1;

    logic [NFF-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) begin
            ff <= '0;
        end else begin
            ff[0] <= async_in;
            for (int i = 1; i < NFF; i++) begin
                ff[i] <= ff[i-1];
            end
        end
    end

    assign toggled = ff[NFF-1] ^ ff[NFF-2];

endmodule

// File: rtl/tx_johnson_ptr.sv
module tx_johnson_ptr #(
    parameter int unsigned N = 7,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [N-1:0]     q,
    output logic [IDX_W-1:0] pos
);
    function automatic logic [N-1:0] step_code(input logic [N-1:0] c);
        return {c[N-2:0], ~c[N-1]};
    endfunction

    function automatic logic [IDX_W-1:0] code_pos(input logic [N-1:0] c);
        int ones;
        ones = $countones(c);
        if (c[N-1]) return IDX_W'(N - ones);
        return IDX_W'(ones);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (adv) q <= step_code(q);
    end

    assign pos = code_pos(q);

    // R4: each step flips exactly one bit, namely the one at the old position
    assert_single_flip_R4: assert property (@(posedge clk) disable iff (rst)
        adv |=> (q ^ $past(q)) == (N'(1) << $past(pos)));

endmodule

// File: rtl/tx_credit_tracker.sv
module tx_credit_tracker
    import tx_credit_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DEPTH  = DEF_SLOTS,
    parameter int unsigned SYNC   = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] link_data,
    output logic              link_req,
    input  logic              link_ack,
    output logic [DEPTH-1:0]  slot_free
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        phase_e            req;
    } link_t;

    link_t             lnk;
    logic [DEPTH-1:0]  wr_q, rd_q;
    logic [IDX_W-1:0]  wr_pos, rd_pos;
    logic              ack_seen;
    logic              accept;

    tx_ack_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (link_ack),
        .toggled  (ack_seen)
    );

    tx_johnson_ptr #(.N(DEPTH)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .q   (wr_q),
        .pos (wr_pos)
    );

    tx_johnson_ptr #(.N(DEPTH)) u_rd_ptr (
        .clk (clk),
        .rst (rst),
        .adv (ack_seen),
        .q   (rd_q),
        .pos (rd_pos)
    );

    assign slot_free = ~(wr_q ^ rd_q);
    assign in_ready  = slot_free[wr_pos];
    assign accept    = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            lnk.data <= '0;
            lnk.req  <= PHASE_LO;
        end else if (accept) begin
            lnk.data <= in_data;
            lnk.req  <= phase_flip(lnk.req);
        end
    end

    assign link_data = lnk.data;
    assign link_req  = lnk.req;

    // R2: an accepted flit inverts the request
    assert_req_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (link_req != $past(link_req)));

    // R3: never announce a flit when every slot is occupied
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (link_req != $past(link_req)) |-> ($past(slot_free) != '0));

    // R4: the written slot reads occupied afterwards
    assert_slot_taken_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> !slot_free[$past(wr_pos)]);

    // R5: an acknowledge retires an occupied slot, and only that one is freed
    assert_ack_hits_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ack_seen |-> !slot_free[rd_pos]);
    assert_ack_frees_one_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_seen && !accept) |=>
            ($countones(slot_free) == $past($countones(slot_free)) + 1));

    // R6: link holds without an accepted flit
    assert_link_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> ($stable(link_data) && $stable(link_req)));

endmodule

// File: tb/test_tx_credit_tracker.sv
module test_tx_credit_tracker;
    localparam int W = 16;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] link_data;
    logic         link_req;
    logic         link_ack = 1'b0;
    logic [N-1:0] slot_free;

    tx_credit_tracker #(.DATA_W(W), .DEPTH(N), .SYNC(2)) i_tx_credit_tracker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .link_data(link_data), .link_req(link_req),
        .link_ack(link_ack), .slot_free(slot_free)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    bit [N-1:0] exp_busy = '0;
    int         widx = 0, ridx = 0;
    bit         p0 = 0, p1 = 0;
    bit         exp_req = 0;
    logic [W-1:0] exp_data = '0;
    int         accepted = 0, acked = 0;
    bit [3:0]   acc_d = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic bit exp_ready();
        return !exp_busy[widx];
    endfunction

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic step(input bit v, input logic [W-1:0] d, input bit ackt);
        bit acc;
        in_valid = v;
        in_data  = d;
        if (ackt) begin
            link_ack = ~link_ack;
            acked++;
        end
        acc = v && exp_ready();
        @(posedge clk);
        if (p1) begin
            exp_busy[ridx] = 1'b0;
            ridx = (ridx + 1) % N;
        end
        p1 = p0;
        p0 = ackt;
        if (acc) begin
            exp_busy[widx] = 1'b1;
            widx = (widx + 1) % N;
            exp_req = ~exp_req;
            exp_data = d;
            accepted++;
        end
        acc_d = {acc_d[2:0], acc};
        @(negedge clk);
        chk(in_ready === exp_ready(), "R3", "in_ready", 32'(in_ready), 32'(exp_ready()));
        chk(slot_free === ~exp_busy, "R4", "slot_free", 32'(slot_free), 32'(~exp_busy));
        chk(link_req === exp_req, "R2", "link_req", 32'(link_req), 32'(exp_req));
        chk(link_data === exp_data, "R6", "link_data", 32'(link_data), 32'(exp_data));
    endtask

    task automatic drain();
        while (acked < accepted) step(1'b0, '0, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(link_req === 1'b0, "R1", "req in reset", 32'(link_req), 0);
        chk(slot_free === '1, "R1", "free in reset", 32'(slot_free), 32'h7f);
        chk(in_ready === 1'b1, "R1", "ready in reset", 32'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(slot_free === '1 && link_req === 1'b0, "R1", "after reset",
            32'({link_req, slot_free}), 32'h7f);

        // R3/R4: fill all slots, then an offered flit must stall
        for (int i = 0; i < N; i++) step(1'b1, W'(16'hA000 + i), 1'b0);
        chk(slot_free === '0, "R4", "full after 7", 32'(slot_free), 0);
        step(1'b1, W'(16'hBEEF), 1'b0);
        chk(link_req === 1'b1 && link_data === W'(16'hA006), "R3",
            "no write when full", 32'(link_data), 32'hA006);

        // R5: freed exactly on the third edge after the ack inversion
        step(1'b0, '0, 1'b1);
        chk(slot_free[0] === 1'b0, "R5", "free after 1 edge", 32'(slot_free[0]), 0);
        step(1'b0, '0, 1'b0);
        chk(slot_free[0] === 1'b0, "R5", "free after 2 edges", 32'(slot_free[0]), 0);
        step(1'b0, '0, 1'b0);
        chk(slot_free[0] === 1'b1, "R5", "free after 3 edges", 32'(slot_free[0]), 1);
        drain();

        // R7: full-rate stream with a three-cycle acknowledge loop
        acc_d = '0;
        for (int i = 0; i < 40; i++) begin
            chk(in_ready === 1'b1, "R7", "ready in stream", 32'(in_ready), 1);
            step(1'b1, W'($urandom), acc_d[3]);
        end
        drain();

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            bit v, a;
            v = ($urandom % 10) < 7;
            a = (acked < accepted) && (($urandom % 10) < 4);
            step(v, W'($urandom), a);
        end
        drain();

        // R8: wrap consistency
        chk(slot_free === '1, "R8", "all free after drain", 32'(slot_free), 32'h7f);
        chk(link_req === 1'(accepted % 2), "R8", "req parity",
            32'(link_req), 32'(accepted % 2));
        finish_run();
    end
endmodule